// File: doc/BRIEF.md
# Register command parser

This block sits behind a byte-oriented serial receiver and turns the stream of received bytes into register accesses on a small parameter file. Each received byte comes with a one-cycle strobe. The parser decodes a command byte. It then either collects the argument bytes that a write needs or loads a response that the serial transmitter shifts out during the following transfers. The next byte to transmit is always shown on `tx_byte`, and it is 0x00 when no response is pending.

Reads return a snapshot taken when the command is decoded. A later read that produces a response replaces whatever is left of an earlier one. Writes are checked against the device state, which arrives on two inputs: the power stage is in high impedance, and the motor is stopped.

Errors come out as one-cycle set pulses for the external status flags. An illegal target is reported as soon as its command byte arrives. A write whose condition is not met is reported only after its last argument byte. The status command returns the externally held status word and pulses a clear request.

Top module: `regcmd_engine`

## Requirements
- R1: While reset is held, and after it is released, `tx_byte` is 0x00, every pulse output is low, and all writable registers read back as zero.
- R2: The byte 0x00 is a no-operation. It writes nothing and raises no flag, and it only moves a pending response on by one byte.
- R3: A read is the byte 001 followed by a 5-bit address: 0x01 position (22 bits, 3 bytes), 0x02 electrical position (9 bits, 2 bytes), 0x04 speed (20 bits, 3 bytes), 0x05 acceleration (12 bits, 2 bytes), 0x18 configuration (16 bits, 2 bytes), 0x19 status (16 bits, 2 bytes). The response is sent most significant byte first, with the bits above the register width at zero. A response byte is shown on `tx_byte` in the cycle after a byte is received, and it advances by one at each later received byte.
- R4: A write is the byte 000 followed by a 5-bit address of a writable register (0x01, 0x02, 0x05, 0x18). It takes that register's byte count of argument bytes, most significant byte first. It pulses `wr_en` once, in the cycle after the last argument byte, with the data masked to the register width.
- R5: A write to speed (0x04), to status (0x19) or to an unmapped address pulses `err_wrong` in the cycle after the command byte. The bytes that follow are decoded as new commands.
- R6: Writes to electrical position and configuration need `hiz_i` high, and writes to acceleration need `stopped_i` high. These inputs are sampled with the last argument byte. When the condition fails, `err_noperf` pulses instead of `wr_en` and the register keeps its value.
- R7: Argument bytes are never decoded as commands, even when they match a command encoding.
- R8: Response bytes are fixed when the read is decoded. Later writes and input changes do not alter a response already loaded.
- R9: A command that produces a response, received while an earlier response is still pending, drops the rest of the earlier response and starts its own.
- R10: Commands received while a response is being sent are decoded and executed, and the response keeps advancing.
- R11: The byte 0xD0 loads the 16-bit status input as a 2-byte response and pulses `sts_clr`. A read of address 0x19 returns the same word without `sts_clr`.
- R12: A read of an unmapped address, and any byte that is neither a read, a write, 0x00 nor 0xD0, pulses `err_wrong` and loads no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| hiz_i | input | 1 | Power stage is in high impedance |
| stopped_i | input | 1 | Motor is stopped |
| speed_i | input | 20 | Current speed value (read-only register) |
| sts_i | input | 16 | Current status word (read-only register) |
| tx_byte | output | 8 | Next byte to transmit |
| wr_en | output | 1 | Register write pulse |
| wr_addr | output | 5 | Address of the register written |
| wr_data | output | 24 | Written value, masked to the register width |
| err_wrong | output | 1 | Set pulse for the wrong-command flag |
| err_noperf | output | 1 | Set pulse for the not-performable flag |
| sts_clr | output | 1 | Request to clear the latched status flags |

## Verification
A parser stuck in the argument state shows up at the ports as a missing error pulse, or as a missing response after the next command byte. It appears in the cycle after that byte. A wrong count of remaining arguments gives a `wr_en` one byte early or late. A wrong response counter or alignment corrupts `tx_byte` at the first or the last response byte. Comparing every cycle against a byte-queue model catches each of these within one transfer of the fault.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  localparam logic [4:0] A_ABS = 5'h01;
  localparam logic [4:0] A_EL  = 5'h02;
  localparam logic [4:0] A_SPD = 5'h04;
  localparam logic [4:0] A_ACC = 5'h05;
  localparam logic [4:0] A_CFG = 5'h18;
  localparam logic [4:0] A_STS = 5'h19;
  localparam logic [7:0] OP_NOP    = 8'h00;
  localparam logic [7:0] OP_STATUS = 8'hD0;
  localparam int MAX_BYTES = 3;
  localparam int DATA_W    = 8 * MAX_BYTES;

  typedef enum logic [2:0] {K_NOP, K_SET, K_GET, K_STAT, K_BAD} cmd_kind_e;
  typedef enum logic {ST_CMD, ST_ARG} pstate_e;

  typedef struct packed {
    cmd_kind_e  kind;
    logic [4:0] addr;
    logic [1:0] nbytes;
    logic       need_hiz;
    logic       need_stop;
  } dec_t;
endpackage

// File: rtl/regcmd_decode.sv
module regcmd_decode
  import regcmd_pkg::*;
#(
  parameter int ABS_W = 22,
  parameter int EL_W  = 9,
  parameter int SPD_W = 20,
  parameter int ACC_W = 12,
  parameter int CFG_W = 16,
  parameter int STS_W = 16
) (
  input  logic [7:0] cmd,
  output dec_t       dec
);
  localparam logic [1:0] L_ABS = 2'((ABS_W + 7) / 8);
  localparam logic [1:0] L_EL  = 2'((EL_W  + 7) / 8);
  localparam logic [1:0] L_SPD = 2'((SPD_W + 7) / 8);
  localparam logic [1:0] L_ACC = 2'((ACC_W + 7) / 8);
  localparam logic [1:0] L_CFG = 2'((CFG_W + 7) / 8);
  localparam logic [1:0] L_STS = 2'((STS_W + 7) / 8);

  always_comb begin
    dec           = '0;
    dec.kind      = K_BAD;
    dec.addr      = cmd[4:0];
    if (cmd == OP_NOP) begin
      dec.kind = K_NOP;
    end else if (cmd == OP_STATUS) begin
      dec.kind   = K_STAT;
      dec.addr   = A_STS;
      dec.nbytes = L_STS;
    end else if (cmd[7:5] == 3'b000) begin
      unique case (cmd[4:0])
        A_ABS:   begin dec.kind = K_SET; dec.nbytes = L_ABS; end
        A_EL:    begin dec.kind = K_SET; dec.nbytes = L_EL;  dec.need_hiz  = 1'b1; end
        A_ACC:   begin dec.kind = K_SET; dec.nbytes = L_ACC; dec.need_stop = 1'b1; end
        A_CFG:   begin dec.kind = K_SET; dec.nbytes = L_CFG; dec.need_hiz  = 1'b1; end
        default: dec.kind = K_BAD;
      endcase
    end else if (cmd[7:5] == 3'b001) begin
      unique case (cmd[4:0])
        A_ABS:   begin dec.kind = K_GET; dec.nbytes = L_ABS; end
        A_EL:    begin dec.kind = K_GET; dec.nbytes = L_EL;  end
        A_SPD:   begin dec.kind = K_GET; dec.nbytes = L_SPD; end
        A_ACC:   begin dec.kind = K_GET; dec.nbytes = L_ACC; end
        A_CFG:   begin dec.kind = K_GET; dec.nbytes = L_CFG; end
        A_STS:   begin dec.kind = K_GET; dec.nbytes = L_STS; end
        default: dec.kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/regcmd_regfile.sv
module regcmd_regfile
  import regcmd_pkg::*;
#(
  parameter int ABS_W = 22,
  parameter int EL_W  = 9,
  parameter int SPD_W = 20,
  parameter int ACC_W = 12,
  parameter int CFG_W = 16,
  parameter int STS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [4:0]        waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SPD_W-1:0]  speed_i,
  input  logic [STS_W-1:0]  sts_i,
  input  logic [4:0]        raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [ABS_W-1:0] abs_q;
  logic [EL_W-1:0]  el_q;
  logic [ACC_W-1:0] acc_q;
  logic [CFG_W-1:0] cfg_q;
  logic             unused_wbits;

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abs_q <= '0;
      el_q  <= '0;
      acc_q <= '0;
      cfg_q <= '0;
    end else if (we) begin
      if (waddr == A_ABS) abs_q <= wdata[ABS_W-1:0];
      if (waddr == A_EL)  el_q  <= wdata[EL_W-1:0];
      if (waddr == A_ACC) acc_q <= wdata[ACC_W-1:0];
      if (waddr == A_CFG) cfg_q <= wdata[CFG_W-1:0];
    end
  end

  always_comb begin
    unique case (raddr)
      A_ABS:   rdata = DATA_W'(abs_q);
      A_EL:    rdata = DATA_W'(el_q);
      A_SPD:   rdata = DATA_W'(speed_i);
      A_ACC:   rdata = DATA_W'(acc_q);
      A_CFG:   rdata = DATA_W'(cfg_q);
      A_STS:   rdata = DATA_W'(sts_i);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/regcmd_resp.sv
module regcmd_resp
  import regcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [1:0]        load_len,
  output logic [7:0]        tx_byte
);
  logic [DATA_W-1:0] buf_q, buf_d;
  logic [1:0]        cnt_q, cnt_d;

  always_comb begin
    buf_d = buf_q;
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_len;
      unique case (load_len)
        2'd1:    buf_d = {load_data[7:0], 16'h0};
        2'd2:    buf_d = {load_data[15:0], 8'h0};
        default: buf_d = load_data;
      endcase
    end else if (advance && cnt_q != 2'd0) begin
      buf_d = {buf_q[DATA_W-9:0], 8'h0};
      cnt_d = cnt_q - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (load || advance) begin
      buf_q <= buf_d;
      cnt_q <= cnt_d;
    end
  end

  assign tx_byte = (cnt_q != 2'd0) ? buf_q[DATA_W-1:DATA_W-8] : 8'h00;
endmodule

// File: rtl/regcmd_engine.sv
module regcmd_engine
  import regcmd_pkg::*;
#(
  parameter int ABS_W = 22,
  parameter int EL_W  = 9,
  parameter int SPD_W = 20,
  parameter int ACC_W = 12,
  parameter int CFG_W = 16,
  parameter int STS_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        hiz_i,
  input  logic        stopped_i,
  input  logic [19:0] speed_i,
  input  logic [15:0] sts_i,
  output logic [7:0]  tx_byte,
  output logic        wr_en,
  output logic [4:0]  wr_addr,
  output logic [23:0] wr_data,
  output logic        err_wrong,
  output logic        err_noperf,
  output logic        sts_clr
);
  dec_t              dec;
  pstate_e           state_q, state_d;
  logic [1:0]        left_q, left_d;
  logic [4:0]        aaddr_q, aaddr_d;
  logic              ahiz_q, ahiz_d, astop_q, astop_d;
  logic [DATA_W-1:0] adata_q, adata_d;
  logic              wr_en_d, wrong_d, noperf_d, clr_d;
  logic [4:0]        wr_addr_d;
  logic [DATA_W-1:0] wr_data_d, rdata;
  logic              resp_load;
  logic              unused_hi;

  assign unused_hi = ^adata_q[DATA_W-1:DATA_W-8];

  function automatic logic [DATA_W-1:0] wmask(input logic [4:0] a);
    unique case (a)
      A_ABS:   return {DATA_W{1'b1}} >> (DATA_W - ABS_W);
      A_EL:    return {DATA_W{1'b1}} >> (DATA_W - EL_W);
      A_ACC:   return {DATA_W{1'b1}} >> (DATA_W - ACC_W);
      A_CFG:   return {DATA_W{1'b1}} >> (DATA_W - CFG_W);
      default: return '0;
    endcase
  endfunction

  regcmd_decode #(.ABS_W(ABS_W), .EL_W(EL_W), .SPD_W(SPD_W), .ACC_W(ACC_W),
                  .CFG_W(CFG_W), .STS_W(STS_W))
    u_dec (.cmd(rx_byte), .dec(dec));

  regcmd_regfile #(.ABS_W(ABS_W), .EL_W(EL_W), .SPD_W(SPD_W), .ACC_W(ACC_W),
                   .CFG_W(CFG_W), .STS_W(STS_W))
    u_rf (.clk(clk), .rst_n(rst_n), .we(wr_en_d), .waddr(wr_addr_d),
          .wdata(wr_data_d), .speed_i(speed_i), .sts_i(sts_i),
          .raddr(dec.addr), .rdata(rdata));

  regcmd_resp u_resp (.clk(clk), .rst_n(rst_n), .advance(rx_valid),
                      .load(resp_load), .load_data(rdata),
                      .load_len(dec.nbytes), .tx_byte(tx_byte));

  always_comb begin
    state_d   = state_q;
    left_d    = left_q;
    aaddr_d   = aaddr_q;
    ahiz_d    = ahiz_q;
    astop_d   = astop_q;
    adata_d   = adata_q;
    wr_en_d   = 1'b0;
    wrong_d   = 1'b0;
    noperf_d  = 1'b0;
    clr_d     = 1'b0;
    wr_addr_d = wr_addr;
    wr_data_d = wr_data;
    resp_load = 1'b0;
    if (rx_valid) begin
      if (state_q == ST_CMD) begin
        unique case (dec.kind)
          K_SET: begin
            state_d = ST_ARG;
            left_d  = dec.nbytes;
            aaddr_d = dec.addr;
            ahiz_d  = dec.need_hiz;
            astop_d = dec.need_stop;
            adata_d = '0;
          end
          K_GET:   resp_load = 1'b1;
          K_STAT:  begin resp_load = 1'b1; clr_d = 1'b1; end
          K_BAD:   wrong_d = 1'b1;
          default: ;
        endcase
      end else begin
        adata_d = {adata_q[DATA_W-9:0], rx_byte};
        left_d  = left_q - 2'd1;
        if (left_q == 2'd1) begin
          state_d = ST_CMD;
          if ((!ahiz_q || hiz_i) && (!astop_q || stopped_i)) begin
            wr_en_d   = 1'b1;
            wr_addr_d = aaddr_q;
            wr_data_d = adata_d & wmask(aaddr_q);
          end else begin
            noperf_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_CMD;
      left_q     <= '0;
      aaddr_q    <= '0;
      ahiz_q     <= 1'b0;
      astop_q    <= 1'b0;
      adata_q    <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      err_wrong  <= 1'b0;
      err_noperf <= 1'b0;
      sts_clr    <= 1'b0;
    end else begin
      wr_en      <= wr_en_d;
      err_wrong  <= wrong_d;
      err_noperf <= noperf_d;
      sts_clr    <= clr_d;
      if (rx_valid) begin
        state_q <= state_d;
        left_q  <= left_d;
        aaddr_q <= aaddr_d;
        ahiz_q  <= ahiz_d;
        astop_q <= astop_d;
        adata_q <= adata_d;
        wr_addr <= wr_addr_d;
        wr_data <= wr_data_d;
      end
    end
  end
endmodule

// File: rtl/regcmd_engine_chk.sv
module regcmd_engine_chk
  import regcmd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        hiz_i,
  input logic        stopped_i,
  input logic [7:0]  tx_byte,
  input logic        wr_en,
  input logic [4:0]  wr_addr,
  input logic [23:0] wr_data,
  input logic        err_wrong,
  input logic        err_noperf,
  input logic        sts_clr
);
  AST_PULSE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || err_wrong || err_noperf || sts_clr) |-> $past(rx_valid)); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, err_wrong, err_noperf, sts_clr})); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_valid) |-> $stable(tx_byte)); // R8
  AST_HIZ_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_EL || wr_addr == A_CFG)) |-> $past(hiz_i)); // R6
  AST_STOP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ACC) |-> $past(stopped_i)); // R6
  AST_WR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr == A_ABS || wr_addr == A_EL ||
               wr_addr == A_ACC || wr_addr == A_CFG)); // R5
  AST_EL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_EL) |-> (wr_data[23:9] == 15'h0)); // R4
endmodule

bind regcmd_engine regcmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .hiz_i(hiz_i),
  .stopped_i(stopped_i), .tx_byte(tx_byte), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .err_wrong(err_wrong),
  .err_noperf(err_noperf), .sts_clr(sts_clr));

// File: tb/test_regcmd_engine.sv
module test_regcmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        hiz_i = 1'b0;
  logic        stopped_i = 1'b0;
  logic [19:0] speed_i = 20'h0;
  logic [15:0] sts_i = 16'h0;
  logic [7:0]  tx_byte;
  logic        wr_en, err_wrong, err_noperf, sts_clr;
  logic [4:0]  wr_addr;
  logic [23:0] wr_data;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit    running = 1'b0;

  // reference model state
  byte unsigned q[$];
  int  m_abs = 0, m_el = 0, m_acc = 0, m_cfg = 0;
  bit  in_arg = 0;
  int  a_addr = 0, a_left = 0, a_data = 0;
  bit  e_wr = 0, e_wrong = 0, e_np = 0, e_clr = 0;
  int  e_addr = 0, e_data = 0;

  regcmd_engine i_regcmd_engine (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .hiz_i(hiz_i), .stopped_i(stopped_i), .speed_i(speed_i), .sts_i(sts_i),
    .tx_byte(tx_byte), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_wrong(err_wrong), .err_noperf(err_noperf), .sts_clr(sts_clr));

  always #10 clk = ~clk;

  function automatic int width_of(int a);
    case (a)
      1: return 22;  2: return 9;  4: return 20;
      5: return 12;  24: return 16; 25: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic int value_of(int a);
    case (a)
      1: return m_abs;  2: return m_el;  4: return int'(speed_i);
      5: return m_acc;  24: return m_cfg; 25: return int'(sts_i);
      default: return 0;
    endcase
  endfunction

  function automatic void load_resp(int a);
    int n = (width_of(a) + 7) / 8;
    int v = value_of(a);
    q.delete();
    for (int i = n - 1; i >= 0; i--) q.push_back(8'((v >> (8 * i)) & 8'hFF));
  endfunction

  function automatic void step(byte unsigned b);
    if (q.size() > 0) void'(q.pop_front());
    if (in_arg) begin
      a_data = (a_data << 8) | b;
      a_left--;
      if (a_left == 0) begin
        bit ok;
        in_arg = 0;
        ok = 1;
        if ((a_addr == 2 || a_addr == 24) && !hiz_i) ok = 0;
        if (a_addr == 5 && !stopped_i) ok = 0;
        if (ok) begin
          int v = a_data & ((1 << width_of(a_addr)) - 1);
          e_wr = 1; e_addr = a_addr; e_data = v;
          case (a_addr)
            1: m_abs = v;  2: m_el = v;  5: m_acc = v;  24: m_cfg = v;
            default: ;
          endcase
        end else e_np = 1;
      end
    end else if (b == 8'h00) begin
    end else if (b == 8'hD0) begin
      load_resp(25); e_clr = 1;
    end else if (b[7:5] == 3'b000) begin
      int a = b[4:0];
      if (a == 1 || a == 2 || a == 5 || a == 24) begin
        in_arg = 1; a_addr = a; a_data = 0;
        a_left = (width_of(a) + 7) / 8;
      end else e_wrong = 1;
    end else if (b[7:5] == 3'b001) begin
      if (width_of(b[4:0]) != 0) load_resp(b[4:0]);
      else e_wrong = 1;
    end else e_wrong = 1;
  endfunction

  task automatic send(byte unsigned b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1 step(b);
    @(negedge clk);
    rx_valid = 1'b0;
    @(posedge clk); #1;
    e_wr = 0; e_wrong = 0; e_np = 0; e_clr = 0;
    @(negedge clk);
  endtask

  task automatic cmp(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s got=%0h exp=%0h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      cmp("tx_byte", int'(tx_byte), (q.size() > 0) ? int'(q[0]) : 0);
      cmp("wr_en", int'(wr_en), int'(e_wr));
      cmp("err_wrong", int'(err_wrong), int'(e_wrong));
      cmp("err_noperf", int'(err_noperf), int'(e_np));
      cmp("sts_clr", int'(sts_clr), int'(e_clr));
      if (e_wr) begin
        cmp("wr_addr", int'(wr_addr), e_addr);
        cmp("wr_data", int'(wr_data), e_data);
      end
    end
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state, during reset and after release
    repeat (3) @(negedge clk);
    cur_req = "R1";
    cmp("tx in reset", int'(tx_byte), 0);
    cmp("pulses in reset", int'({wr_en, err_wrong, err_noperf, sts_clr}), 0);
    rst_n = 1'b1;
    running = 1'b1;
    repeat (2) @(negedge clk);
    send(8'h21); send(8'h00); send(8'h00); send(8'h00);
    send(8'h38); send(8'h00); send(8'h00);

    // R4: position write, surplus bits dropped
    cur_req = "R4";
    send(8'h01); send(8'hFF); send(8'h12); send(8'h34);
    // R3 and R2: read back MSB first, NOPs move it on
    cur_req = "R3";
    send(8'h21);
    cur_req = "R2";
    send(8'h00); send(8'h00); send(8'h00); send(8'h00);

    // R3 and R8: speed snapshot held while input changes
    cur_req = "R8";
    speed_i = 20'hABCDE;
    send(8'h24);
    speed_i = 20'h12345;
    send(8'h00); send(8'h00); send(8'h00);

    // R6: condition checks
    cur_req = "R6";
    hiz_i = 1'b0;
    send(8'h02); send(8'h01); send(8'hFF);
    send(8'h22); send(8'h00); send(8'h00);
    hiz_i = 1'b1;
    send(8'h02); send(8'hFF); send(8'hFF);
    send(8'h22); send(8'h00); send(8'h00);
    stopped_i = 1'b0;
    send(8'h05); send(8'h0A); send(8'hBC);
    stopped_i = 1'b1;
    send(8'h05); send(8'hFA); send(8'hBC);
    send(8'h25); send(8'h00); send(8'h00);
    hiz_i = 1'b0;
    send(8'h18); send(8'hBE);
    hiz_i = 1'b1;
    send(8'hEF);
    send(8'h38); send(8'h00); send(8'h00);
    send(8'h18); send(8'h11);
    hiz_i = 1'b0;
    send(8'h22);
    send(8'h38); send(8'h00); send(8'h00);

    // R5: illegal write targets, following bytes are commands
    cur_req = "R5";
    send(8'h04); send(8'h21); send(8'h00);
    send(8'h19); send(8'h07); send(8'h00); send(8'h00); send(8'h00);

    // R7: argument bytes that look like commands
    cur_req = "R7";
    send(8'h01); send(8'h21); send(8'hD0); send(8'h3F);
    send(8'h21); send(8'h00); send(8'h00); send(8'h00);

    // R9: new read preempts pending response
    cur_req = "R9";
    send(8'h21); send(8'h25); send(8'h00); send(8'h00);

    // R10: write executes while a response is being sent
    cur_req = "R10";
    send(8'h21); send(8'h05); send(8'h00); send(8'h77);
    send(8'h25); send(8'h00); send(8'h00);

    // R11: status command vs status read
    cur_req = "R11";
    sts_i = 16'hA55A;
    send(8'hD0);
    sts_i = 16'h0F0F;
    send(8'h00); send(8'h00);
    send(8'h39); send(8'h00); send(8'h00);

    // R12: unmapped read and unknown opcodes
    cur_req = "R12";
    send(8'h3F); send(8'h80); send(8'hFF); send(8'h23); send(8'h00);

    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule